// File: doc/BRIEF.md
# Dual-Mode Delay Code Register

This block holds the 8-bit code that sets the delay of a programmable timing element. The code can be written in two ways over one shared set of pins. In parallel mode, a transparent latch passes the eight bus inputs into the code while the latch enable is high. In serial mode, three bus bits are reused as serial clock, serial data in and serial data out, and they feed an MSB-first shift register. The delay logic never sees the shift register directly. It sees a separate active register that loads from the shift register only when the latch enable falls.

All pins are sampled on the system clock. A serial clock edge is a sampled 0-to-1 transition of bus bit 1. Bits leave on the serial output as new bits enter, so several units can be chained, eight bits per unit. Looping the serial output back to the input reads the code and restores it at the same time. A one-cycle pulse marks every change of the active code, so a downstream block can model the settling interval.

Top module: `dly_code_reg`

## Requirements
- R1: `ser_mode` = 0 selects parallel loading and `ser_mode` = 1 selects serial loading.
- R2: In parallel mode with `latch_en` high, `code` equals the `pbus_in` value sampled at the previous clock edge. The shift register takes the same value.
- R3: In parallel mode with `latch_en` low, changes on `pbus_in` leave `code` unchanged.
- R4: In serial mode with `latch_en` high, a sampled rising edge of `pbus_in[1]` shifts the register one place toward bit 7, taking `pbus_in[2]` into bit 0. Codes are therefore sent MSB first.
- R5: In serial mode, `code` stays frozen while `latch_en` is high. At the first clock edge that samples `latch_en` low after it was high, `code` loads the shift register contents.
- R6: In serial mode, `sdo` shows shift register bit 7. When `latch_en` rises with the serial clock low, `sdo` shows bit 7 of the stored value. Each serial clock edge then presents the next older bit, MSB first.
- R7: Eight serial clocks with `sdo` looped to `pbus_in[2]`, followed by a fall of `latch_en`, leave `code` unchanged and raise no `code_updated` pulse.
- R8: `sdo_oe` is 1 in serial mode and 0 in parallel mode. In parallel mode `sdo` is 0.
- R9: Reset clears `code`, the shift register and `code_updated` to 0.
- R10: `code_updated` is high for exactly the cycle in which `code` first shows a new value. Writing the same value again raises no pulse.
- R11: In serial mode, serial clock edges while `latch_en` is low do not alter the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_mode | input | 1 | 0 = parallel, 1 = serial |
| latch_en | input | 1 | Latch enable for both modes |
| pbus_in | input | 8 | Parallel code; in serial mode bit 1 = serial clock, bit 2 = serial data |
| sdo | output | 1 | Serial data out (bus bit 0 in serial mode) |
| sdo_oe | output | 1 | Output enable for sdo |
| code | output | 8 | Active delay code |
| code_updated | output | 1 | One-cycle pulse when code changes |

## Verification
The following properties are checked on every cycle:
- the parallel path follows the bus while the latch enable is high;
- the code holds while the latch enable stays low;
- the serial freeze while shifting and the load on the latch enable fall;
- the shift step;
- that an update pulse always coincides with a changed code;
- that the output stays quiet when it is not enabled.

Some behaviours appear only as scenario results, and only the bench's sequences show them:
- the whole MSB-first order in which an old code leaves;
- the lossless loop-back readback over eight clocks;
- the rejection of serial clocks while the latch enable is low;
- the absence of a pulse when a code is rewritten with its own value.

// File: rtl/dly_code_reg.sv
module dly_code_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_mode,
  input  logic       latch_en,
  input  logic [7:0] pbus_in,
  output logic       sdo,
  output logic       sdo_oe,
  output logic [7:0] code,
  output logic       code_updated
);

  logic       le_q, sck_q;
  logic [7:0] sreg, sreg_d, code_d;
  logic       sck_rise, par_load, ser_load, ser_shift;

  assign sck_rise  = pbus_in[1] & ~sck_q;
  assign par_load  = ~ser_mode & latch_en;
  assign ser_shift = ser_mode & latch_en & sck_rise;
  assign ser_load  = ser_mode & le_q & ~latch_en;

  always_comb begin
    sreg_d = sreg;
    if (par_load)       sreg_d = pbus_in;
    else if (ser_shift) sreg_d = {sreg[6:0], pbus_in[2]};
  end

  always_comb begin
    code_d = code;
    if (par_load)      code_d = pbus_in;
    else if (ser_load) code_d = sreg;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      le_q         <= 1'b0;
      sck_q        <= 1'b0;
      sreg         <= '0;
      code         <= '0;
      code_updated <= 1'b0;
    end else begin
      le_q         <= latch_en;
      sck_q        <= pbus_in[1];
      sreg         <= sreg_d;
      code         <= code_d;
      code_updated <= (code_d != code);
    end
  end

  assign sdo_oe = ser_mode;
  assign sdo    = ser_mode & sreg[7];

  assert_par_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_mode && latch_en) |=> (code == $past(pbus_in)));

  assert_par_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_en && !le_q) |=> $stable(code));

  assert_shift_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_mode && latch_en && sck_rise) |=> (sreg == {$past(sreg[6:0]), $past(pbus_in[2])}));

  assert_ser_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_mode && latch_en) |=> $stable(code));

  assert_ser_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_mode && le_q && !latch_en) |=> (code == $past(sreg)));

  assert_quiet_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);

  assert_pulse_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
    code_updated |-> (code != $past(code)));

endmodule

// File: tb/dly_code_reg_tb.sv
module dly_code_reg_tb;
  logic clk = 1'b0, rst_n = 1'b0, ser_mode = 1'b0, latch_en = 1'b0;
  logic [7:0] pbus_in = '0;
  logic sdo, sdo_oe, code_updated;
  logic [7:0] code;
  int n_cmp = 0, n_bad = 0, cyc = 0;

  int    kind_q[$];
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  dly_code_reg u_dut (.clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .latch_en(latch_en),
    .pbus_in(pbus_in), .sdo(sdo), .sdo_oe(sdo_oe), .code(code), .code_updated(code_updated));

  task automatic expect_item(input int k, input logic [7:0] e, input string t);
    kind_q.push_back(k); exp_q.push_back(e); tag_q.push_back(t);
  endtask

  always @(negedge clk) begin
    #2;
    while (kind_q.size() > 0) begin
      int k; logic [7:0] e, a; string t;
      k = kind_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
      case (k)
        0: a = code;
        1: a = {7'd0, sdo};
        2: a = {7'd0, code_updated};
        default: a = {7'd0, sdo_oe};
      endcase
      n_cmp++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", t, k, a, e);
      end
    end
  end

  task automatic step(input logic m, input logic le, input logic [7:0] p);
    #3;
    ser_mode = m; latch_en = le; pbus_in = p;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic ser_bit(input logic d);
    step(1'b1, 1'b1, {5'd0, d, 2'b00});
    step(1'b1, 1'b1, {5'd0, d, 2'b10});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_item(0, 8'h00, "R9 code after reset");
    expect_item(2, 8'h00, "R9 pulse after reset");
    expect_item(3, 8'h00, "R8 oe in parallel");
    expect_item(1, 8'h00, "R8 sdo in parallel");

    step(1'b0, 1'b1, 8'hA5);
    expect_item(0, 8'hA5, "R2 R1 parallel follow");
    expect_item(2, 8'h01, "R10 pulse on change");
    step(1'b0, 1'b1, 8'hA5);
    expect_item(2, 8'h00, "R10 single cycle pulse");
    step(1'b0, 1'b1, 8'h3C);
    expect_item(0, 8'h3C, "R2 second value");
    step(1'b0, 1'b0, 8'hFF);
    step(1'b0, 1'b0, 8'h81);
    expect_item(0, 8'h3C, "R3 latched hold");
    expect_item(2, 8'h00, "R3 no pulse");

    step(1'b1, 1'b0, 8'h00);
    expect_item(3, 8'h01, "R8 R1 oe in serial");
    step(1'b1, 1'b1, 8'h00);
    expect_item(1, 8'h00, "R6 bit7 on latch rise");
    for (int i = 7; i >= 0; i--) begin
      logic [7:0] nv = 8'h96;
      logic [7:0] ov = 8'h3C;
      ser_bit(nv[i]);
      if (i > 0) expect_item(1, {7'd0, ov[i-1]}, "R6 old bit out");
      else       expect_item(1, {7'd0, nv[7]}, "R4 new msb at sdo");
      expect_item(0, 8'h3C, "R5 frozen while shifting");
    end
    step(1'b1, 1'b0, 8'h00);
    expect_item(0, 8'h96, "R5 R4 load on latch fall");
    expect_item(2, 8'h01, "R10 pulse on serial load");
    step(1'b1, 1'b0, 8'h00);
    expect_item(2, 8'h00, "R10 pulse ends");

    for (int i = 0; i < 4; i++) begin
      step(1'b1, 1'b0, 8'h04);
      step(1'b1, 1'b0, 8'h06);
    end
    step(1'b1, 1'b0, 8'h00);
    step(1'b1, 1'b1, 8'h00);
    expect_item(1, 8'h01, "R11 msb kept");
    step(1'b1, 1'b0, 8'h00);
    expect_item(0, 8'h96, "R11 ignored clocks");
    expect_item(2, 8'h00, "R11 no pulse");

    step(1'b1, 1'b1, 8'h00);
    for (int i = 7; i >= 0; i--) begin
      logic [7:0] rv = 8'h96;
      logic d;
      d = sdo;
      if (d !== rv[i]) begin
        n_cmp++; n_bad++;
        $display("FAIL R7 readback bit actual=%b expected=%b", d, rv[i]);
      end else n_cmp++;
      ser_bit(d);
    end
    step(1'b1, 1'b0, 8'h00);
    expect_item(0, 8'h96, "R7 loopback restores");
    expect_item(2, 8'h00, "R7 no pulse");

    step(1'b0, 1'b0, 8'h00);
    expect_item(3, 8'h00, "R8 oe back off");
    expect_item(1, 8'h00, "R8 sdo zero");
    step(1'b0, 1'b1, 8'h96);
    expect_item(0, 8'h96, "R2 same value");
    expect_item(2, 8'h00, "R10 no pulse same value");
    step(1'b0, 1'b0, 8'h00);
    #4;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<5000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule